// File: doc/BRIEF.md
# Serial Receive Byte-to-DWORD Packer

This block sits behind a receive protocol handler and turns its serial output into 32-bit words for a receive buffer. Each accepted bit is shifted into a byte, the first bit of every byte landing in bit 0. Completed bytes are then gathered into a word. A mode input selects the byte lane order. In little-endian mode the first byte of a word goes in the low lane. In big-endian mode it goes in the high lane.

A word write leaves the block when four bytes are gathered, or when the handler signals the end of a frame. At a frame end the word may be only partly filled. Each write carries a count of valid bytes minus one and a frame-end flag. A frame end with no buffered bytes produces a status-only write, which is marked by an empty flag. Downstream logic can then close a frame without a data word.

The mode input is sampled for each byte. It is expected to stay constant within a frame.

Top module: `rx_dword_packer`

## Requirements
- R1: Bits accepted while `bit_vld` is high fill a byte in arrival order: the first bit goes to bit 0 and the eighth bit to bit 7.
- R2: With `endian_big` = 0, byte k of a word (k = 0..3, in arrival order) is placed in `out_data[8k+7:8k]`.
- R3: With `endian_big` = 1, byte k of a word is placed in `out_data[31-8k:24-8k]`.
- R4: `out_vld` is a single-cycle pulse. It rises in the cycle after a clock edge at which either a fourth byte completes or `frame_end` is high, and at no other time.
- R5: A write caused by a full word has `out_cnt` = 3, and has `out_eof` = 0 unless `frame_end` was high at the same edge.
- R6: When `frame_end` arrives with n buffered bytes (n = 1..4, counting a byte completed at that edge), the write has `out_cnt` = n-1, `out_eof` = 1 and `out_empty` = 0, and all lanes not holding a byte read zero.
- R7: When `frame_end` arrives with no buffered bytes, the write is status-only: `out_data` = 0, `out_cnt` = 0, `out_eof` = 1 and `out_empty` = 1.
- R8: At `frame_end`, the bits of an incomplete byte are discarded, and the next frame starts at bit 0 of byte 0.
- R9: A synchronous reset (`rst` high at a clock edge) clears the bit count, the byte count and the partial word, and drives `out_vld` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial receive bit |
| frame_end | input | 1 | End of frame; applies after the bit accepted in this cycle, if any |
| endian_big | input | 1 | 0: first byte in low lane; 1: first byte in high lane |
| out_vld | output | 1 | Word write strobe |
| out_data | output | 32 | Packed word |
| out_cnt | output | 2 | Number of valid bytes minus one |
| out_eof | output | 1 | The write closes a frame |
| out_empty | output | 1 | Status-only write that carries no bytes |

## Verification
Directed frames first pin down the basic cases. A single byte with only bit 0 set shows the bit order and the lane choice in each mode. A frame end given alone, and one that follows a few stray bits, shows that empty closures and bit discard work. Random frames of zero to nine bytes, with idle gaps and a random mode for each frame, then reach every partial count, as well as frame ends that fall exactly on a word boundary. Those two cases separate a flush caused by a full word from a flush caused by a frame end. A reset taken in mid-frame, followed by a lone frame end, shows whether any stale bytes survive the reset.

// File: rtl/rx_pack_pkg.sv
package rx_pack_pkg;
  // Lane that receives the byte at position idx within a word.
  function automatic int unsigned lane_index(input int unsigned idx, input logic big,
                                             input int unsigned lanes);
    return big ? (lanes - 1 - idx) : idx;
  endfunction
endpackage

// File: rtl/rx_bit_asm.sv
module rx_bit_asm #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_vld,
  input  logic              bit_in,
  input  logic              frame_end,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data
);
  localparam int unsigned CW = $clog2(BYTE_W);

  logic [CW-1:0]     bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              last_bit;

  assign last_bit  = bit_vld && (bit_cnt == CW'(BYTE_W - 1));
  assign byte_vld  = last_bit;
  // Right shift: the earliest bit ends up at position 0.
  assign byte_data = {bit_in, shreg[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else begin
      if (bit_vld) shreg <= {bit_in, shreg[BYTE_W-1:1]};
      if (frame_end || last_bit) bit_cnt <= '0;
      else if (bit_vld)          bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rx_lane_packer.sv
module rx_lane_packer #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      byte_vld,
  input  logic [BYTE_W-1:0]         byte_data,
  input  logic                      frame_end,
  input  logic                      endian_big,
  output logic                      flush_evt,
  output logic [$clog2(LANES)-1:0]  pend_cnt,
  output logic                      out_vld,
  output logic [BYTE_W*LANES-1:0]   out_data,
  output logic [$clog2(LANES)-1:0]  out_cnt,
  output logic                      out_eof,
  output logic                      out_empty
);
  import rx_pack_pkg::*;
  localparam int unsigned WORD_W = BYTE_W * LANES;
  localparam int unsigned CNT_W  = $clog2(LANES);

  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] placed;
  logic [WORD_W-1:0] merged;
  logic [CNT_W:0]    total;
  logic [CNT_W-1:0]  lane;

  always_comb begin
    lane   = CNT_W'(lane_index(int'(pend_cnt), endian_big, LANES));
    placed = byte_vld ? (WORD_W'(byte_data) << (int'(lane) * BYTE_W)) : '0;
    merged = word_q | placed;
    total  = {1'b0, pend_cnt} + (CNT_W+1)'(byte_vld);
  end

  assign flush_evt = frame_end || (byte_vld && pend_cnt == CNT_W'(LANES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q    <= '0;
      pend_cnt  <= '0;
      out_vld   <= 1'b0;
      out_data  <= '0;
      out_cnt   <= '0;
      out_eof   <= 1'b0;
      out_empty <= 1'b0;
    end else begin
      out_vld <= flush_evt;
      if (flush_evt) begin
        out_data  <= merged;
        out_cnt   <= (total == '0) ? '0 : CNT_W'(total - 1'b1);
        out_eof   <= frame_end;
        out_empty <= frame_end && (total == '0);
        word_q    <= '0;
        pend_cnt  <= '0;
      end else if (byte_vld) begin
        word_q   <= merged;
        pend_cnt <= pend_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_dword_packer.sv
module rx_dword_packer #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned WORD_W = BYTE_W * LANES,
  localparam int unsigned CNT_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_vld,
  input  logic              bit_in,
  input  logic              frame_end,
  input  logic              endian_big,
  output logic              out_vld,
  output logic [WORD_W-1:0] out_data,
  output logic [CNT_W-1:0]  out_cnt,
  output logic              out_eof,
  output logic              out_empty
);
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_data;
  logic              flush_evt;
  logic [CNT_W-1:0]  pend_cnt;

  rx_bit_asm #(.BYTE_W(BYTE_W)) u_bits (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .frame_end(frame_end), .byte_vld(byte_vld), .byte_data(byte_data)
  );

  rx_lane_packer #(.BYTE_W(BYTE_W), .LANES(LANES)) u_pack (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
    .frame_end(frame_end), .endian_big(endian_big), .flush_evt(flush_evt),
    .pend_cnt(pend_cnt), .out_vld(out_vld), .out_data(out_data),
    .out_cnt(out_cnt), .out_eof(out_eof), .out_empty(out_empty)
  );
endmodule

// File: rtl/rx_dword_packer_chk.sv
module rx_dword_packer_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CNT_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_end,
  input logic              byte_vld,
  input logic [CNT_W-1:0]  pend_cnt,
  input logic              out_vld,
  input logic [WORD_W-1:0] out_data,
  input logic [CNT_W-1:0]  out_cnt,
  input logic              out_eof,
  input logic              out_empty
);
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !(byte_vld || frame_end) |=> !out_vld);

  a_r5_full_word: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && pend_cnt == {CNT_W{1'b1}}) |=> (out_vld && out_cnt == {CNT_W{1'b1}}));

  a_r6_eof_flush: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (out_vld && out_eof));

  a_r7_empty_status: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_empty) |-> (out_cnt == '0 && out_data == '0 && out_eof));

  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (!out_vld && pend_cnt == '0));
endmodule

bind rx_dword_packer rx_dword_packer_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .frame_end(frame_end), .byte_vld(byte_vld),
  .pend_cnt(pend_cnt), .out_vld(out_vld), .out_data(out_data),
  .out_cnt(out_cnt), .out_eof(out_eof), .out_empty(out_empty)
);

// File: tb/rx_dword_packer_tb.sv
module rx_dword_packer_tb;
  logic clk = 1'b0;
  logic rst = 1'b1, bit_vld = 1'b0, bit_in = 1'b0, frame_end = 1'b0, endian_big = 1'b0;
  logic        out_vld, out_eof, out_empty;
  logic [31:0] out_data;
  logic [1:0]  out_cnt;

  always #4 clk = ~clk;  // 125 MHz

  rx_dword_packer u_dut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in), .frame_end(frame_end),
    .endian_big(endian_big), .out_vld(out_vld), .out_data(out_data),
    .out_cnt(out_cnt), .out_eof(out_eof), .out_empty(out_empty)
  );

  int checks = 0, fails = 0;

  // Reference model state
  logic [7:0]  m_bits;
  int          m_nbit = 0;
  logic [7:0]  m_bytes [4];
  int          m_nb = 0;
  logic        e_vld = 0, e_eof = 0, e_empty = 0;
  logic [31:0] e_data = 0;
  logic [1:0]  e_cnt = 0;
  logic        e_big = 0;

  function automatic logic [31:0] pack_ref(input logic [7:0] b [4], input int n, input logic big);
    logic [31:0] w = '0;
    for (int k = 0; k < n; k++) begin
      int lane = big ? 3 - k : k;
      w[lane*8 +: 8] = b[k];
    end
    return w;
  endfunction

  task automatic check(input string req, input logic ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare_outputs();
    string tag;
    check("R4 out_vld", out_vld === e_vld, 64'(out_vld), 64'(e_vld));
    if (e_vld && out_vld === 1'b1) begin
      tag = e_empty ? "R7" : (e_eof ? "R6" : (e_big ? "R3" : "R2"));
      check({tag, " data"}, out_data === e_data, 64'(out_data), 64'(e_data));
      check({e_eof ? tag : "R5", " cnt"}, out_cnt === e_cnt, 64'(out_cnt), 64'(e_cnt));
      check({tag, " eof"}, out_eof === e_eof, 64'(out_eof), 64'(e_eof));
      check({tag, " empty"}, out_empty === e_empty, 64'(out_empty), 64'(e_empty));
    end
  endtask

  // One clock: check the previous edge's result, drive inputs, predict this edge.
  task automatic step(input logic r, input logic bv, input logic b, input logic fe);
    @(negedge clk);
    compare_outputs();
    rst = r; bit_vld = bv; bit_in = b; frame_end = fe;
    e_vld = 0;
    if (r) begin
      m_nbit = 0; m_nb = 0;
      return;
    end
    if (bv) begin
      m_bits[m_nbit] = b;
      m_nbit++;
      if (m_nbit == 8) begin
        m_bytes[m_nb] = m_bits;
        m_nb++;
        m_nbit = 0;
      end
    end
    if (fe || m_nb == 4) begin
      e_vld   = 1;
      e_big   = endian_big;
      e_data  = pack_ref(m_bytes, m_nb, endian_big);
      e_cnt   = (m_nb == 0) ? 2'd0 : 2'(m_nb - 1);
      e_eof   = fe;
      e_empty = fe && (m_nb == 0);
      m_nb = 0;
      if (fe) m_nbit = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] v, input logic fe_on_last);
    for (int i = 0; i < 8; i++) step(0, 1, v[i], fe_on_last && i == 7);
  endtask

  initial begin
    #1600000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    step(0, 0, 0, 0);  // R9 reset state: out_vld low
    // R1/R2: single byte 0x01 little endian, frame end on last bit
    endian_big = 0;
    send_byte(8'h01, 1);
    step(0, 0, 0, 0);
    // R1/R3: same in big endian -> top lane
    endian_big = 1;
    send_byte(8'h01, 1);
    step(0, 0, 0, 0);
    // R5/R2: full word then frame end alone (R7)
    endian_big = 0;
    send_byte(8'hA1, 0); send_byte(8'hB2, 0); send_byte(8'hC3, 0); send_byte(8'hD4, 0);
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    // R8: stray bits then frame end -> empty write, next frame clean
    for (int i = 0; i < 5; i++) step(0, 1, 1, 0);
    step(0, 0, 0, 1);
    send_byte(8'h5A, 0); send_byte(8'h3C, 1);  // R6 two-byte partial
    step(0, 0, 0, 0);
    // R9: reset mid-frame discards pending bytes
    send_byte(8'hEE, 0);
    for (int i = 0; i < 3; i++) step(0, 1, 1, 0);
    step(1, 0, 0, 0);
    step(0, 0, 0, 1);  // expect empty write
    step(0, 0, 0, 0);
    // Random frames
    void'($urandom(32'h1234_5678));
    for (int f = 0; f < 300; f++) begin
      int nbytes = $urandom_range(0, 9);
      endian_big = 1'($urandom_range(0, 1));
      for (int k = 0; k < nbytes; k++) begin
        logic [7:0] v = 8'($urandom);
        for (int i = 0; i < 8; i++) begin
          if ($urandom_range(0, 5) == 0) step(0, 0, 0, 0);
          step(0, 1, v[i], 0);
        end
      end
      if ($urandom_range(0, 3) == 0)
        for (int i = 0; i < $urandom_range(1, 7); i++) step(0, 1, 1'($urandom), 0);
      step(0, 0, 0, 1);
      step(0, 0, 0, 0);
    end
    step(0, 0, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule